// File: doc/BRIEF.md
# Four-Entry Fully-Associative Byte Cache

This block places a tiny cache between a requester and a slower byte-wide memory. It holds four one-byte entries, and any address can sit in any entry. On every access the requested address is compared against all valid entries at once. A read that finds its address is answered from the entry without touching memory. A read that misses fetches the byte over a request/ready handshake, installs it, and returns it. Every write is also sent on to memory. A write that misses installs the byte in the cache directly, without a read.

Replacement is least-recently-used, tracked with timestamps. A free-running access count increases by one on each completed access, and the new count is copied into the entry that access touched. On a miss, the lowest-numbered empty entry is filled first. Once all four entries are full, the entry holding the smallest count is replaced. Only one request is in flight at a time: the requester holds its request until a one-cycle completion pulse arrives. Running hit and miss totals are exposed on output ports.

Top module: `assoc_byte_cache`

## Requirements
- R1: After reset every entry is empty, `hit_count` and `miss_count` read 0, `rsp_done` and `mem_req` are low, and the first access of any address misses.
- R2: Any address may occupy any entry: four distinct addresses that share all low-order bits can be resident together and all hit afterwards.
- R3: A read hit returns the stored byte with `rsp_hit`=1 on `rsp_done` one cycle after the request is presented, and raises no memory request.
- R4: A read miss raises one memory read (`mem_write`=0) at the requested address. The byte returned with `mem_ready` is delivered on `rsp_rdata` with `rsp_hit`=0, and a repeat read then hits.
- R5: A miss fills an empty entry when one exists. When all entries are valid, a miss replaces the entry whose last access is the oldest.
- R6: Every completed access, whether hit, miss, read or write, makes the touched entry the most recently used. The stored access count only increases and never wraps.
- R7: Every write raises a memory write with `mem_addr`/`mem_wdata` equal to the request. A write hit updates the cached byte. A write miss installs the byte without any memory read. `rsp_rdata` echoes the written byte, and `rsp_hit` reports whether the address was present.
- R8: `rsp_done` is a one-cycle pulse per access, with `rsp_hit` valid alongside it. Exactly one of `hit_count` or `miss_count` rises by one per access.
- R9: `mem_req` stays high with stable `mem_addr` and `mem_write` until `mem_ready`. A `mem_ready` while no request is open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `rsp_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read byte (write byte echoed on writes) |
| rsp_hit | output | 1 | Address was resident, valid with `rsp_done` |
| mem_req | output | 1 | Memory access open |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write byte |
| mem_ready | input | 1 | Memory completes the open access |
| mem_rdata | input | DATA_W | Memory read byte, valid with `mem_ready` |
| hit_count | output | CNT_W | Total hits since reset |
| miss_count | output | CNT_W | Total misses since reset |

## Verification
In the cycle a request is accepted, the lookup does two things at once. It decides hit or miss and picks a replacement candidate from the stored counts. If that access is a read hit, the same cycle also rewrites the matched entry's count. The bench provokes this by refreshing an old entry with a read hit and, right after, sending a miss to a full cache. It judges the result by which address misses when read again. A long pseudo-random sweep over eight addresses that all share their low bits mixes refreshes, evictions, write hits and write misses at varied memory latency. Each response is compared against a recency model kept in the bench.

// File: rtl/acache_pkg.sv
package acache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } acc_state_e;
endpackage

// File: rtl/acache_match.sv
module acache_match #(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0]             valid,
  input  logic [SLOTS-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]            addr,
  output logic [SLOTS-1:0]             hit_vec,
  output logic                         any_hit,
  output logic [IDX_W-1:0]             hit_idx
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == addr);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/acache_victim.sv
module acache_victim #(
  parameter int SLOTS   = 4,
  parameter int STAMP_W = 16,
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0]              valid,
  input  logic [SLOTS-1:0][STAMP_W-1:0] stamps,
  output logic [IDX_W-1:0]              vic_idx
);
  logic              found_empty;
  logic [STAMP_W-1:0] oldest;

  always_comb begin
    found_empty = 1'b0;
    vic_idx     = '0;
    oldest      = stamps[0];
    for (int i = 0; i < SLOTS; i++) begin
      if (!valid[i] && !found_empty) begin
        found_empty = 1'b1;
        vic_idx     = IDX_W'(i);
      end
    end
    if (!found_empty) begin
      for (int i = 1; i < SLOTS; i++) begin
        if (stamps[i] < oldest) begin
          oldest  = stamps[i];
          vic_idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/acache_ctrl.sv
module acache_ctrl
  import acache_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       any_hit,
  input  logic       mem_ready,
  output acc_state_e state_q,
  output logic       accept,
  output logic       commit
);
  acc_state_e state_d;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    commit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_d = ST_WRITE;
          end else if (any_hit) begin
            commit  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH, ST_WRITE: begin
        if (mem_ready) begin
          commit  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/assoc_byte_cache.sv
module assoc_byte_cache
  import acache_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int SLOTS   = 4,
  parameter int STAMP_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              mem_req,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  acc_state_e state_q;
  logic       accept, commit;

  logic [SLOTS-1:0]              vld_q, vld_d;
  logic [SLOTS-1:0][ADDR_W-1:0]  tag_q, tag_d;
  logic [SLOTS-1:0][DATA_W-1:0]  dat_q, dat_d;
  logic [SLOTS-1:0][STAMP_W-1:0] stm_q, stm_d;
  logic [STAMP_W-1:0]            clk_cnt_q, clk_cnt_d;
  logic [CNT_W-1:0]              hit_cnt_q, hit_cnt_d, miss_cnt_q, miss_cnt_d;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic [IDX_W-1:0]  tgt_q;
  logic              hit_q;

  logic              in_idle;
  logic [ADDR_W-1:0] look_addr;
  logic [SLOTS-1:0]  hit_vec;
  logic              any_hit;
  logic [IDX_W-1:0]  hit_idx, vic_idx, tgt_sel;
  logic              hit_sel;
  logic [DATA_W-1:0] fill_data;

  acache_ctrl u_ctrl (
    .clk, .rst_n, .req_valid, .req_write, .any_hit, .mem_ready,
    .state_q, .accept, .commit
  );

  acache_match #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_match (
    .valid(vld_q), .tags(tag_q), .addr(look_addr),
    .hit_vec, .any_hit, .hit_idx
  );

  acache_victim #(.SLOTS(SLOTS), .STAMP_W(STAMP_W)) u_victim (
    .valid(vld_q), .stamps(stm_q), .vic_idx
  );

  assign in_idle   = (state_q == ST_IDLE);
  assign look_addr = in_idle ? req_addr : addr_q;
  assign tgt_sel   = in_idle ? (any_hit ? hit_idx : vic_idx) : tgt_q;
  assign hit_sel   = in_idle ? any_hit : hit_q;

  always_comb begin
    unique case (state_q)
      ST_WRITE: fill_data = wdata_q;
      ST_FETCH: fill_data = mem_rdata;
      default:  fill_data = dat_q[tgt_sel];
    endcase
  end

  // next-state of the entry store and counters, applied on commit
  always_comb begin
    vld_d      = vld_q;
    tag_d      = tag_q;
    dat_d      = dat_q;
    stm_d      = stm_q;
    clk_cnt_d  = clk_cnt_q + STAMP_W'(1);
    vld_d[tgt_sel] = 1'b1;
    tag_d[tgt_sel] = look_addr;
    dat_d[tgt_sel] = fill_data;
    stm_d[tgt_sel] = clk_cnt_d;
    hit_cnt_d  = hit_cnt_q  + CNT_W'(hit_sel);
    miss_cnt_d = miss_cnt_q + CNT_W'(!hit_sel);
    rdata_d    = in_idle ? dat_q[hit_idx] : fill_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q      <= '0;
      tag_q      <= '0;
      dat_q      <= '0;
      stm_q      <= '0;
      clk_cnt_q  <= '0;
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      tgt_q      <= '0;
      hit_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        tgt_q   <= tgt_sel;
        hit_q   <= any_hit;
      end
      if (commit) begin
        vld_q      <= vld_d;
        tag_q      <= tag_d;
        dat_q      <= dat_d;
        stm_q      <= stm_d;
        clk_cnt_q  <= clk_cnt_d;
        hit_cnt_q  <= hit_cnt_d;
        miss_cnt_q <= miss_cnt_d;
      end
      if (accept || commit) rdata_q <= rdata_d;
    end
  end

  assign mem_req    = (state_q == ST_FETCH) || (state_q == ST_WRITE);
  assign mem_write  = (state_q == ST_WRITE);
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign rsp_done   = (state_q == ST_DONE);
  assign rsp_rdata  = rdata_q;
  assign rsp_hit    = hit_q;
  assign hit_count  = hit_cnt_q;
  assign miss_count = miss_cnt_q;
endmodule

// File: rtl/acache_checker.sv
module acache_checker #(
  parameter int ADDR_W  = 8,
  parameter int SLOTS   = 4,
  parameter int STAMP_W = 16,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_write,
  input logic               rsp_done,
  input logic               rsp_hit,
  input logic               mem_req,
  input logic               mem_write,
  input logic               mem_ready,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count,
  input logic [SLOTS-1:0]   hit_vec,
  input logic [STAMP_W-1:0] stamp_clock
);
  logic [CNT_W:0] total;
  assign total = {1'b0, hit_count} + {1'b0, miss_count};

  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_hit && !req_write) |-> !$past(mem_req));

  a_r6_stamp_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stamp_clock >= $past(stamp_clock)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (total == $past(total) + 1'b1));

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));
endmodule

bind assoc_byte_cache acache_checker #(
  .ADDR_W(ADDR_W), .SLOTS(SLOTS), .STAMP_W(STAMP_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_write(req_write), .rsp_done(rsp_done),
  .rsp_hit(rsp_hit), .mem_req(mem_req), .mem_write(mem_write),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .hit_count(hit_count),
  .miss_count(miss_count), .hit_vec(hit_vec), .stamp_clock(clk_cnt_q)
);

// File: tb/assoc_byte_cache_test.sv
`timescale 1ns/1ps
module assoc_byte_cache_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       rsp_done, rsp_hit, mem_req, mem_write;
  logic [7:0] rsp_rdata, mem_addr, mem_wdata;
  logic       mem_ready = 1'b0;
  logic [7:0] mem_rdata = '0;
  logic [15:0] hit_count, miss_count;

  int checks = 0, failures = 0;
  logic [7:0] mem_model [256];
  bit         ref_vld [4];
  logic [7:0] ref_tag [4], ref_dat [4];
  int         ref_stm [4];
  int         ref_clk = 0, ref_hits = 0, ref_misses = 0;
  logic [15:0] lf;

  always #10 clk = ~clk;

  assoc_byte_cache uut (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
    .rsp_done, .rsp_rdata, .rsp_hit, .mem_req, .mem_write, .mem_addr,
    .mem_wdata, .mem_ready, .mem_rdata, .hit_count, .miss_count
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // recency model: empty entry first, else smallest stamp
  task automatic ref_step(input bit w, input logic [7:0] a, input logic [7:0] d,
                          output bit eh, output logic [7:0] erd);
    int t = -1;
    for (int i = 0; i < 4; i++) if (ref_vld[i] && ref_tag[i] == a) t = i;
    eh = (t >= 0);
    if (!eh) begin
      for (int i = 3; i >= 0; i--) if (!ref_vld[i]) t = i;
      if (t < 0) begin
        t = 0;
        for (int i = 1; i < 4; i++) if (ref_stm[i] < ref_stm[t]) t = i;
      end
    end
    erd = w ? d : (eh ? ref_dat[t] : mem_model[a]);
    ref_clk++;
    ref_vld[t] = 1'b1; ref_tag[t] = a; ref_dat[t] = erd; ref_stm[t] = ref_clk;
    if (eh) ref_hits++; else ref_misses++;
  endtask

  task automatic do_access(input bit w, input logic [7:0] a, input logic [7:0] d,
                           input int lat, input string tag);
    bit eh; logic [7:0] erd;
    int cyc = 0, waited = 0;
    bit saw_rd = 0, saw_wr = 0;
    ref_step(w, a, d, eh, erd);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      cyc++;
      if (rsp_done) break;
      if (cyc > 64) begin
        chk(0, tag, "no completion", cyc, 64);
        break;
      end
      if (mem_req) begin
        if (mem_write) saw_wr = 1; else saw_rd = 1;
        chk(mem_addr == a, "R9", "mem_addr held", mem_addr, a);
        if (mem_write) chk(mem_wdata == d, "R7", "mem_wdata", mem_wdata, d);
        if (waited >= lat) begin
          mem_ready = 1'b1;
          mem_rdata = mem_model[a];
        end else begin
          waited++;
          mem_rdata = 8'hEE;
        end
      end
    end
    mem_ready = 1'b0;
    req_valid = 1'b0;
    if (w) mem_model[a] = d;
    chk(rsp_hit == eh, tag, "hit flag", rsp_hit, eh);
    chk(rsp_rdata == erd, tag, "rdata", rsp_rdata, erd);
    if (eh && !w) begin
      chk(cyc == 1, "R3", "hit latency", cyc, 1);
      chk(!saw_rd && !saw_wr, "R3", "mem traffic on hit", saw_rd | saw_wr, 0);
    end
    if (!eh && !w) chk(saw_rd && !saw_wr, "R4", "miss fetch", saw_rd, 1);
    if (w) chk(saw_wr && !saw_rd, "R7", "write-through only", saw_rd, 0);
    @(negedge clk);
    chk(!rsp_done, "R8", "done pulse width", rsp_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_model[i] = 8'((i * 7 + 3) & 255);
    for (int i = 0; i < 4; i++) begin
      ref_vld[i] = 0; ref_tag[i] = 0; ref_dat[i] = 0; ref_stm[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hit_count == 0, "R1", "hit_count", hit_count, 0);
    chk(miss_count == 0, "R1", "miss_count", miss_count, 0);
    chk(!rsp_done, "R1", "rsp_done", rsp_done, 0);
    chk(!mem_req, "R1", "mem_req", mem_req, 0);

    // R1/R4 first read misses and fetches; R3 repeat hits
    do_access(0, 8'h10, 8'h00, 2, "R4");
    chk(miss_count == 1, "R1", "first access missed", miss_count, 1);
    do_access(0, 8'h10, 8'h00, 0, "R3");

    // R2 four addresses with equal low bits coexist
    do_access(0, 8'h20, 8'h00, 0, "R2");
    do_access(0, 8'h30, 8'h00, 1, "R2");
    do_access(0, 8'h40, 8'h00, 3, "R2");
    for (int i = 1; i <= 4; i++) do_access(0, 8'(i * 16), 8'h00, 0, "R2");

    // R6 refresh 0x10 then R5 miss must evict 0x20
    do_access(0, 8'h10, 8'h00, 0, "R6");
    do_access(0, 8'h50, 8'h00, 1, "R5");
    do_access(0, 8'h10, 8'h00, 0, "R6");
    do_access(0, 8'h20, 8'h00, 0, "R5");
    do_access(0, 8'h40, 8'h00, 0, "R5");

    // R7 write hit and write miss, then readback hits
    do_access(1, 8'h40, 8'hA5, 1, "R7");
    do_access(1, 8'h77, 8'h3C, 2, "R7");
    do_access(0, 8'h77, 8'h00, 0, "R7");
    do_access(0, 8'h40, 8'h00, 0, "R7");

    // R9 stray ready while idle is ignored
    begin
      logic [15:0] h0, m0;
      h0 = hit_count; m0 = miss_count;
      mem_ready = 1'b1; mem_rdata = 8'h99;
      repeat (3) @(negedge clk);
      chk(!mem_req && !rsp_done, "R9", "idle stray ready", mem_req, 0);
      mem_ready = 1'b0;
      chk(hit_count == h0 && miss_count == m0, "R9", "counts untouched",
          hit_count + miss_count, h0 + m0);
      do_access(0, 8'h77, 8'h00, 0, "R9");
    end

    // R5 sweep: eight aliasing addresses, mixed writes and latencies
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_access(lf[7:5] == 3'd0, {lf[2:0], 5'd3}, lf[15:8], int'(lf[4:3]), "R5");
    end

    // R8 totals
    chk(hit_count == 16'(ref_hits), "R8", "hit_count total", hit_count, ref_hits);
    chk(miss_count == 16'(ref_misses), "R8", "miss_count total", miss_count, ref_misses);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule